// File: doc/BRIEF.md
# SDRAM Read Latency and Byte-Mask Data Pipeline

This block reproduces, clock by clock, when a synchronous DRAM device places read data on its data bus and when it commits write data. It can serve as the data-side half of a behavioural memory model, or inside a controller as an aligner that knows in which cycle a read word is due and which byte lanes carry it. Each cycle the block may take a read beat (one word fetched from the array, with its data), a write command with its write data, and the two per-byte mask bits. It drives a 16-bit data output with one output enable per byte. It also issues a write strobe with byte enables.

Read beats come out after a programmable latency of two or three clocks, set by a 3-bit latency code. The masks act at different points for the two directions. On a read, a mask bit silences its byte two clocks after it is sampled, whatever the latency. On a write, a mask bit blocks its byte in the same cycle as the data. A row-close (precharge) input cancels a beat launched in the same cycle. Beats already in flight still drain, so the bus goes idle only after the latency has run out. Storage and column addressing are left to the surrounding logic.

Top module: `sdq_timing`

## Requirements
- R1: The latency code `cl_code` value 3'b010 selects a read latency of 2 clocks and 3'b011 selects 3 clocks.
- R2: Every other value of `cl_code` is reserved: the block then uses a latency of 3. `cl_err` is high in the cycle after each clock edge at which a reserved code was sampled, and low after edges that sampled 3'b010 or 3'b011.
- R3: A read beat (`rd_beat` high, `pre_cut` low) sampled at edge n with latency L appears on `dq_out` from just after edge n+L-1 up to edge n+L, for exactly one cycle. Its data is the `arr_rdata` value sampled at edge n.
- R4: A read mask bit sampled high at edge k clears that byte's enable for the output word that is valid at edge k+2. This holds for both latencies. Bit 0 of `dqm` and `dq_oe` covers bits 7:0, and bit 1 covers bits 15:8.
- R5: When no read beat is due in a cycle, `dq_oe` is 2'b00. Any byte whose enable is low reads 8'h00 on `dq_out`.
- R6: Read beats may be sampled on consecutive clock edges. They then leave the block on consecutive cycles in the same order, with no gap.
- R7: A write (`wr_cmd` high) sampled at edge n raises `wr_stb` for the single cycle after edge n. In that cycle `wr_dout` equals the `wr_din` sampled at edge n, and `wr_be` is the inverse of the `dqm` sampled at that same edge. Without a write, `wr_stb` is low.
- R8: A beat sampled together with `pre_cut` high is dropped. Beats sampled before that edge p still emerge, so output data continues until edge p+L-1 and the bus is idle afterwards.
- R9: A synchronous active-high `rst` clears `dq_oe`, `dq_out`, `wr_stb`, `wr_be`, `wr_dout` and `cl_err`, and empties the read pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_beat | input | 1 | A read word from the array is launched this cycle |
| pre_cut | input | 1 | Row close this cycle; cancels a read beat launched in the same cycle |
| wr_cmd | input | 1 | Write command; its data is taken in the same cycle |
| dqm | input | 2 | Byte masks; bit 0 covers the low byte |
| cl_code | input | 3 | Read latency code |
| arr_rdata | input | 16 | Read word that goes with `rd_beat` |
| wr_din | input | 16 | Write data that goes with `wr_cmd` |
| dq_out | output | 16 | Read data bus value |
| dq_oe | output | 2 | Per-byte output enable; 0 means high impedance |
| wr_stb | output | 1 | Write commit strobe |
| wr_be | output | 2 | Write byte enables |
| wr_dout | output | 16 | Write data to commit |
| cl_err | output | 1 | A reserved latency code was seen |

## Verification
Suppose a stage of the read pipeline holds a wrong valid bit, or the wrong stage is picked as the tap for the current latency. The symptom is a word that appears one cycle early or late, or appears twice, or never appears. This is visible on `dq_oe` no later than three cycles after the beat was launched. A wrong value in the mask delay register shows up as a wrong byte enable two cycles after the mask was sampled. A fault on the write path changes the strobe, the enables or the data in the very next cycle. The directed sequences therefore compare every output on every cycle. They cover both latencies, single beats, back-to-back beats, masks that change from word to word, and a row close in the middle of a stream.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int CL_W      = 3;
  localparam int RD_STAGES = 2;
  localparam int TAP_W     = (RD_STAGES > 1) ? $clog2(RD_STAGES) : 1;
  localparam logic [CL_W-1:0] CL2_CODE = 3'b010;
  localparam logic [CL_W-1:0] CL3_CODE = 3'b011;

  function automatic logic cl_reserved(input logic [CL_W-1:0] code);
    return !(code == CL2_CODE || code == CL3_CODE);
  endfunction
endpackage

// File: rtl/sdq_cl_decode.sv
module sdq_cl_decode
  import sdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CL_W-1:0]  cl_code,
  output logic [TAP_W-1:0] tap_idx,
  output logic             cl_err
);
  // latency 2 taps the first stage; latency 3 (and reserved codes) the last
  assign tap_idx = (cl_code == CL2_CODE) ? TAP_W'(0) : TAP_W'(RD_STAGES - 1);

  always_ff @(posedge clk) begin
    if (rst) cl_err <= 1'b0;
    else     cl_err <= cl_reserved(cl_code);
  end
endmodule

// File: rtl/sdq_rd_pipe.sv
module sdq_rd_pipe #(
  parameter int DW     = 16,
  parameter int STAGES = 2,
  parameter int IW     = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [DW-1:0] din,
  input  logic [IW-1:0] idx,
  output logic          tap_vld,
  output logic [DW-1:0] tap_dat
);
  logic          vld_q [STAGES];
  logic [DW-1:0] dat_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) vld_q[s] <= 1'b0;
    end else begin
      vld_q[0] <= launch;
      for (int s = 1; s < STAGES; s++) vld_q[s] <= vld_q[s-1];
    end
    dat_q[0] <= din;
    for (int s = 1; s < STAGES; s++) dat_q[s] <= dat_q[s-1];
  end

  assign tap_vld = vld_q[idx];
  assign tap_dat = dat_q[idx];
endmodule

// File: rtl/sdq_wr_path.sv
module sdq_wr_path #(
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic [NB-1:0] dqm,
  input  logic [DW-1:0] wr_din,
  output logic          wr_stb,
  output logic [NB-1:0] wr_be,
  output logic [DW-1:0] wr_dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_be   <= '0;
      wr_dout <= '0;
    end else begin
      wr_stb  <= wr_cmd;
      wr_be   <= wr_cmd ? ~dqm : '0;
      wr_dout <= wr_din;
    end
  end
endmodule

// File: rtl/sdq_timing.sv
module sdq_timing
  import sdq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_beat,
  input  logic                 pre_cut,
  input  logic                 wr_cmd,
  input  logic [DW/8-1:0]      dqm,
  input  logic [CL_W-1:0]      cl_code,
  input  logic [DW-1:0]        arr_rdata,
  input  logic [DW-1:0]        wr_din,
  output logic [DW-1:0]        dq_out,
  output logic [DW/8-1:0]      dq_oe,
  output logic                 wr_stb,
  output logic [DW/8-1:0]      wr_be,
  output logic [DW-1:0]        wr_dout,
  output logic                 cl_err
);
  localparam int NB = DW / 8;

  logic [TAP_W-1:0] tap_idx;
  logic             tap_vld;
  logic [DW-1:0]    tap_dat;
  logic [NB-1:0]    mask_q;

  sdq_cl_decode u_dec (
    .clk(clk), .rst(rst), .cl_code(cl_code), .tap_idx(tap_idx), .cl_err(cl_err)
  );

  sdq_rd_pipe #(.DW(DW), .STAGES(RD_STAGES), .IW(TAP_W)) u_pipe (
    .clk(clk), .rst(rst), .launch(rd_beat & ~pre_cut), .din(arr_rdata),
    .idx(tap_idx), .tap_vld(tap_vld), .tap_dat(tap_dat)
  );

  sdq_wr_path #(.DW(DW), .NB(NB)) u_wr (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .dqm(dqm), .wr_din(wr_din),
    .wr_stb(wr_stb), .wr_be(wr_be), .wr_dout(wr_dout)
  );

  // read mask: first register here, second is the output register (2 clocks)
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= dqm;
  end

  always_ff @(posedge clk) begin
    if (rst)          dq_oe <= '0;
    else if (tap_vld) dq_oe <= ~mask_q;
    else              dq_oe <= '0;
  end

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst)                      lane_q <= 8'h00;
        else if (tap_vld && !mask_q[b]) lane_q <= tap_dat[b*8 +: 8];
        else                          lane_q <= 8'h00;
      end
      assign dq_out[b*8 +: 8] = lane_q;
    end
  endgenerate
endmodule

// File: rtl/sdq_timing_chk.sv
module sdq_timing_chk
  import sdq_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_beat,
  input logic                 pre_cut,
  input logic                 wr_cmd,
  input logic [DW/8-1:0]      dqm,
  input logic [CL_W-1:0]      cl_code,
  input logic [DW-1:0]        arr_rdata,
  input logic [DW-1:0]        wr_din,
  input logic [DW-1:0]        dq_out,
  input logic [DW/8-1:0]      dq_oe,
  input logic                 wr_stb,
  input logic [DW/8-1:0]      wr_be,
  input logic [DW-1:0]        wr_dout,
  input logic                 cl_err
);
  localparam int NB = DW / 8;
  logic [1:0]    cyc;
  logic          go;
  logic [DW-1:0] lane_en;

  assign go = rd_beat & ~pre_cut;

  always_ff @(posedge clk) begin
    if (rst)              cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  always_comb begin
    for (int i = 0; i < DW; i++) lane_en[i] = dq_oe[i/8];
  end

  // R2
  cl_err_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1) |-> (cl_err == !($past(cl_code) == 3'b010 || $past(cl_code) == 3'b011)));

  // R3 R4 R5 (latency 2)
  rd_cl2_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2 && cl_code == 3'b010 && $past(cl_code) == 3'b010 && $past(cl_code, 2) == 3'b010)
    |-> (dq_oe == ($past(go, 2) ? ~$past(dqm, 2) : '0)));

  // R3 R4 R5 (latency 3, reserved codes included)
  rd_cl3_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && cl_code != 3'b010 && $past(cl_code) != 3'b010 && $past(cl_code, 2) != 3'b010)
    |-> (dq_oe == ($past(go, 3) ? ~$past(dqm, 2) : '0)));

  // R5
  dq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_out & ~lane_en) == '0);

  // R7
  wr_now_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> (wr_stb && wr_be == ~$past(dqm) && wr_dout == $past(wr_din)));

  // R7
  wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_cmd |=> !wr_stb);
endmodule

bind sdq_timing sdq_timing_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_sdq_timing.sv
module sim_sdq_timing;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_beat = 1'b0, pre_cut = 1'b0, wr_cmd = 1'b0;
  logic [1:0]  dqm = 2'b00;
  logic [2:0]  cl_code = 3'b010;
  logic [15:0] arr_rdata = 16'h0, wr_din = 16'h0;
  logic [15:0] dq_out, wr_dout;
  logic [1:0]  dq_oe, wr_be;
  logic        wr_stb, cl_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic        sb [16];
  logic        sc [16];
  logic [1:0]  sm [16];
  logic [15:0] sd [16];

  always #5 clk = ~clk;

  sdq_timing u0 (
    .clk(clk), .rst(rst), .rd_beat(rd_beat), .pre_cut(pre_cut), .wr_cmd(wr_cmd),
    .dqm(dqm), .cl_code(cl_code), .arr_rdata(arr_rdata), .wr_din(wr_din),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_stb(wr_stb), .wr_be(wr_be),
    .wr_dout(wr_dout), .cl_err(cl_err)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_seq();
    for (int i = 0; i < 16; i++) begin
      sb[i] = 1'b0; sc[i] = 1'b0; sm[i] = 2'b00; sd[i] = 16'h0;
    end
  endtask

  task automatic idle(input int n);
    rd_beat = 0; pre_cut = 0; wr_cmd = 0; dqm = 2'b00;
    repeat (n) @(negedge clk);
  endtask

  // drives the stored sequence and compares the bus every cycle
  task automatic run_seq(input string tag, input logic [2:0] code, input int lat);
    cl_code = code;
    idle(4);
    for (int c = 0; c < 20; c++) begin
      logic       vld;
      logic [1:0] pm, eoe;
      logic [15:0] edq;
      int j;
      rd_beat   = (c < 16) ? sb[c] : 1'b0;
      pre_cut   = (c < 16) ? sc[c] : 1'b0;
      dqm       = (c < 16) ? sm[c] : 2'b00;
      arr_rdata = (c < 16) ? sd[c] : 16'h0;
      @(negedge clk);
      j = c - lat + 1;
      vld = 1'b0;
      edq = 16'h0;
      if (j >= 0 && j < 16) vld = sb[j] && !sc[j];
      pm = (c >= 1 && c <= 16) ? sm[c-1] : 2'b00;
      eoe = vld ? ~pm : 2'b00;
      if (eoe[0]) edq[7:0]  = sd[j][7:0];
      if (eoe[1]) edq[15:8] = sd[j][15:8];
      check({tag, " oe"}, {14'h0, dq_oe}, {14'h0, eoe});
      check({tag, " dq"}, dq_out, edq);
    end
    idle(1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    check("R9 reset oe", {14'h0, dq_oe}, 16'h0);
    check("R9 reset dq", dq_out, 16'h0);
    check("R9 reset wr_stb", {15'h0, wr_stb}, 16'h0);
    check("R9 reset wr_be", {14'h0, wr_be}, 16'h0);
    check("R9 reset cl_err", {15'h0, cl_err}, 16'h0);
    rst = 1'b0;
    idle(2);
    check("R5 idle oe", {14'h0, dq_oe}, 16'h0);
  endtask

  task automatic t_single_cl2();
    clear_seq();
    sb[2] = 1; sd[2] = 16'hA55A;
    run_seq("R1/R3/R5 cl2 single", 3'b010, 2);
  endtask

  task automatic t_single_cl3();
    clear_seq();
    sb[1] = 1; sd[1] = 16'h3C21;
    run_seq("R1/R3/R5 cl3 single", 3'b011, 3);
  endtask

  task automatic t_stream();
    clear_seq();
    for (int i = 0; i < 6; i++) begin sb[i+1] = 1; sd[i+1] = 16'h1100 + 16'(i * 16'h0111); end
    run_seq("R6 cl2 stream", 3'b010, 2);
    run_seq("R6 cl3 stream", 3'b011, 3);
  endtask

  task automatic t_mask();
    clear_seq();
    for (int i = 0; i < 8; i++) begin
      sb[i+1] = 1; sd[i+1] = 16'hBE00 + 16'(i);
      sm[i+1] = 2'(i);
    end
    sm[9] = 2'b11; sm[10] = 2'b10;
    run_seq("R4 cl2 mask", 3'b010, 2);
    run_seq("R4 cl3 mask", 3'b011, 3);
  endtask

  task automatic t_cut();
    clear_seq();
    for (int i = 0; i < 6; i++) begin sb[i] = 1; sd[i] = 16'hC000 + 16'(i); end
    sc[3] = 1; sb[4] = 0; sb[5] = 0;
    run_seq("R8 cl2 cut", 3'b010, 2);
    run_seq("R8 cl3 cut", 3'b011, 3);
  endtask

  task automatic t_reserved();
    cl_code = 3'b000;
    idle(2);
    check("R2 reserved flag", {15'h0, cl_err}, 16'h1);
    clear_seq();
    sb[2] = 1; sd[2] = 16'h7E81; sb[3] = 1; sd[3] = 16'h0F0F;
    run_seq("R2 reserved lat3", 3'b111, 3);
    check("R2 reserved flag 111", {15'h0, cl_err}, 16'h1);
    cl_code = 3'b011;
    idle(1);
    check("R2 flag clears", {15'h0, cl_err}, 16'h0);
  endtask

  task automatic t_write();
    idle(2);
    wr_cmd = 1; wr_din = 16'hD00D; dqm = 2'b10;
    @(negedge clk);
    check("R7 wr_stb", {15'h0, wr_stb}, 16'h1);
    check("R7 wr_be", {14'h0, wr_be}, 16'h0001);
    check("R7 wr_dout", wr_dout, 16'hD00D);
    wr_din = 16'h4242; dqm = 2'b00;
    @(negedge clk);
    check("R7 wr back-to-back be", {14'h0, wr_be}, 16'h0003);
    check("R7 wr back-to-back data", wr_dout, 16'h4242);
    wr_cmd = 0; dqm = 2'b11;
    @(negedge clk);
    check("R7 wr_stb low", {15'h0, wr_stb}, 16'h0);
    check("R5 write leaves bus idle", {14'h0, dq_oe}, 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_single_cl2();
    t_single_cl3();
    t_stream();
    t_mask();
    t_cut();
    t_reserved();
    t_write();
    finish_run();
  end
endmodule